// File: doc/BRIEF.md
# Protected Translation Lookaside Cache

This block caches recent page translations for a processor's load/store path. A request carries a virtual address, an access kind (read or write) and the privilege mode (user or kernel). The virtual page number is compared against every stored tag at once. In the same combinational step, the permission bits of the matching entry are checked for that mode and access kind. One clock later a registered result reports one of three outcomes: a hit with the physical address, a miss, or a protection fault.

Each entry holds the following:
- a tag;
- a frame number;
- four permission bits;
- a valid flag;
- two page-status flags, "used" and "modified", which describe the page itself.

The result also reports the entry's page-status flags as they stood before this access. A table walker refills entries through the fill port. Supervisor software removes a single stale translation by its page number, or flushes the whole table in one cycle.

The lookup port and the fill port use valid/ready handshakes. A request is taken on a clock edge where both valid and ready are high. The lookup input is ready whenever the result register is empty or its result is being taken in the same cycle. A result stays on the outputs, unchanged, until it is taken. The fill port is ready except in cycles where an invalidation is requested. The invalidation inputs are plain control pins.

Top module: `prot_tlb`

## Requirements
- R1: After reset the result register is empty (rs_valid=0), lk_ready=1, fl_ready=1 and no entry is valid. A lookup whose page number matches no valid entry returns status 0 (miss), with rs_pa=0, rs_used=0 and rs_dirty=0.
- R2: A lookup that matches a valid entry and is permitted returns status 1 (hit). Its rs_pa is the entry's frame number in the upper bits, followed by the request's untranslated 13-bit page offset. rs_valid rises on the edge that follows acceptance of the request.
- R3: The permission bit checked is fl_perm index {lk_kernel, lk_write}: bit 0 is user read, bit 1 user write, bit 2 kernel read and bit 3 kernel write. A match whose checked bit is 0 returns status 2 (fault) with rs_pa=0.
- R4: rs_used reports the entry's used flag as it was before the access. Any accepted lookup that matches the entry, whether it hits or faults, sets the flag. A fill clears it.
- R5: rs_dirty reports the entry's modified flag as it was before the access. A fill loads the flag from fl_dirty. A permitted write hit sets it. A faulting write leaves it unchanged.
- R6: A fill goes into an invalid entry whenever one exists, and no valid translation is lost.
- R7: When every entry is valid, a fill replaces the entry under a rotating pointer. The pointer is 0 after reset and moves to the next index after each such replacement.
- R8: inv_en clears the valid flag of the entry whose tag equals inv_vpn. Lookups accepted from the next edge on miss that page, and other entries are unaffected.
- R9: inv_all clears every valid flag on one edge.
- R10: While rs_valid=1 and rs_ready=0, lk_ready is 0 and the result outputs hold their values. Results leave in the order their requests were accepted.
- R11: fl_ready is 0 in any cycle where inv_en or inv_all is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_va | input | 48 | Virtual address: page number in bits 47:13, offset in bits 12:0 |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_status | output | 2 | 0 miss, 1 hit, 2 fault |
| rs_pa | output | 45 | Physical address on hit, otherwise 0 |
| rs_used | output | 1 | Entry used flag before this access |
| rs_dirty | output | 1 | Entry modified flag before this access |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill can be taken |
| fl_vpn | input | 35 | Page number to install |
| fl_pfn | input | 32 | Frame number to install |
| fl_perm | input | 4 | Permission bits, layout as in R3 |
| fl_dirty | input | 1 | Initial modified flag |
| inv_en | input | 1 | Invalidate the entry matching inv_vpn |
| inv_vpn | input | 35 | Page number to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
A lookup result is due on the edge after the request is accepted, and it stays until the consumer takes it. Fills, invalidations and flag updates change the outcome only for lookups accepted from the following edge on. The driver changes inputs only on falling edges and spaces operations by at least one idle cycle. The scoreboard monitor samples a quarter period after each falling edge and compares each taken result, in order, with the queued expectation. The stall check reads lk_ready and the held result during a window of three or more cycles in which rs_ready is low.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_HIT   = 2'd1,
    ST_FAULT = 2'd2
  } tlb_status_e;

  localparam int PERM_W = 4;
endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 35
) (
  input  logic [VPN_W-1:0]          vpn,
  input  logic [VPN_W-1:0]          tags  [ENTRIES],
  input  logic [ENTRIES-1:0]        valid,
  input  logic [tlb_pkg::PERM_W-1:0] perms [ENTRIES],
  input  logic                      is_write,
  input  logic                      is_kernel,
  output logic [ENTRIES-1:0]        hit_vec,
  output logic [ENTRIES-1:0]        allow_vec
);
  // Every entry compares its tag and evaluates its permission in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec[g]   = valid[g] && (tags[g] == vpn);
    assign allow_vec[g] = perms[g][{is_kernel, is_write}];
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               take,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valid;
  assign victim   = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R6: while any slot is empty the chosen slot is an empty one
  assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid[victim]);
endmodule

// File: rtl/prot_tlb.sv
module prot_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 35,
  parameter int OFF_W   = 13,
  parameter int PFN_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [VPN_W+OFF_W-1:0]   lk_va,
  input  logic                     lk_write,
  input  logic                     lk_kernel,
  output logic                     rs_valid,
  input  logic                     rs_ready,
  output logic [1:0]               rs_status,
  output logic [PFN_W+OFF_W-1:0]   rs_pa,
  output logic                     rs_used,
  output logic                     rs_dirty,
  input  logic                     fl_valid,
  output logic                     fl_ready,
  input  logic [VPN_W-1:0]         fl_vpn,
  input  logic [PFN_W-1:0]         fl_pfn,
  input  logic [tlb_pkg::PERM_W-1:0] fl_perm,
  input  logic                     fl_dirty,
  input  logic                     inv_en,
  input  logic [VPN_W-1:0]         inv_vpn,
  input  logic                     inv_all
);
  import tlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W  = PFN_W + OFF_W;

  logic [VPN_W-1:0]  tag_q  [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [PERM_W-1:0] perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, used_q, dirty_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] hit_vec, allow_vec, inv_hit;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic               any_hit, hit_ok, lk_fire, fl_fire;

  assign lk_vpn   = lk_va[VPN_W+OFF_W-1:OFF_W];
  assign lk_off   = lk_va[OFF_W-1:0];
  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign fl_ready = !inv_en && !inv_all;
  assign fl_fire  = fl_valid && fl_ready;

  tlb_match_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .vpn(lk_vpn), .tags(tag_q), .valid(valid_q), .perms(perm_q),
    .is_write(lk_write), .is_kernel(lk_kernel),
    .hit_vec(hit_vec), .allow_vec(allow_vec)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .take(fl_fire), .victim(victim)
  );

  // Single-entry invalidation compare, one comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_inv
    assign inv_hit[g] = valid_q[g] && (tag_q[g] == inv_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign hit_ok  = any_hit && allow_vec[hit_idx];

  // Translation payload: written only by fills.
  always_ff @(posedge clk) begin
    if (fl_fire) begin
      tag_q[victim]  <= fl_vpn;
      pfn_q[victim]  <= fl_pfn;
      perm_q[victim] <= fl_perm;
    end
  end

  // Entry state flags; a fill overrides a same-edge flag update.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
    end else begin
      if (lk_fire && any_hit) begin
        used_q[hit_idx] <= 1'b1;
        if (lk_write && hit_ok) dirty_q[hit_idx] <= 1'b1;
      end
      if (inv_all)     valid_q <= '0;
      else if (inv_en) valid_q <= valid_q & ~inv_hit;
      if (fl_fire) begin
        valid_q[victim] <= 1'b1;
        used_q[victim]  <= 1'b0;
        dirty_q[victim] <= fl_dirty;
      end
    end
  end

  // Registered result stage with back-pressure.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_status <= ST_MISS;
      rs_pa     <= '0;
      rs_used   <= 1'b0;
      rs_dirty  <= 1'b0;
    end else if (lk_fire) begin
      rs_valid  <= 1'b1;
      rs_status <= !any_hit ? ST_MISS : (hit_ok ? ST_HIT : ST_FAULT);
      rs_pa     <= hit_ok ? {pfn_q[hit_idx], lk_off} : PA_W'(0);
      rs_used   <= any_hit && used_q[hit_idx];
      rs_dirty  <= any_hit && dirty_q[hit_idx];
    end else if (rs_ready) begin
      rs_valid  <= 1'b0;
    end
  end

  // R10: a stalled result is held unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_pa) && $stable(rs_status)));

  // R1: a request with no tag match reports a miss
  assert_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && !any_hit) |=> (rs_status == ST_MISS));

  // R3: a match whose permission is denied reports a fault
  assert_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && any_hit && ((hit_vec & allow_vec) == '0)) |=> (rs_status == ST_FAULT));

  // R6: a fill leaves its target slot valid
  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_fire |=> valid_q[$past(victim)]);

  // R8: the matched entry is gone after invalidation
  assert_inv_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !inv_all && !fl_fire) |=> ((valid_q & $past(inv_hit)) == '0));

  // R9: a flush empties the table
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));
endmodule

// File: tb/tb_prot_tlb.sv
module tb_prot_tlb;
  localparam int CLK_P = 10;
  localparam int VPN_W = 35;
  localparam int OFF_W = 13;
  localparam int PFN_W = 32;
  localparam int PA_W  = PFN_W + OFF_W;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_write = 0, lk_kernel = 0, rs_ready = 1;
  logic [VPN_W+OFF_W-1:0] lk_va = '0;
  logic lk_ready, rs_valid, rs_used, rs_dirty, fl_ready;
  logic [1:0] rs_status;
  logic [PA_W-1:0] rs_pa;
  logic fl_valid = 0, fl_dirty = 0, inv_en = 0, inv_all = 0;
  logic [VPN_W-1:0] fl_vpn = '0, inv_vpn = '0;
  logic [PFN_W-1:0] fl_pfn = '0;
  logic [3:0] fl_perm = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]      st;
    logic [PA_W-1:0] pa;
    logic            u;
    logic            d;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  always #(CLK_P/2) clk = ~clk;

  prot_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .lk_write(lk_write), .lk_kernel(lk_kernel), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_status(rs_status), .rs_pa(rs_pa), .rs_used(rs_used), .rs_dirty(rs_dirty),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
    .fl_perm(fl_perm), .fl_dirty(fl_dirty), .inv_en(inv_en), .inv_vpn(inv_vpn),
    .inv_all(inv_all)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each taken result with the oldest expectation.
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && rs_valid && rs_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R10 unexpected result", 64'(rs_status), 64'hF);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rs_status == e.st, {t, " status"}, 64'(rs_status), 64'(e.st));
        chk(rs_pa == e.pa, {t, " pa"}, 64'(rs_pa), 64'(e.pa));
        chk(rs_used == e.u, {t, " used"}, 64'(rs_used), 64'(e.u));
        chk(rs_dirty == e.d, {t, " dirty"}, 64'(rs_dirty), 64'(e.d));
      end
    end
  end

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input logic wr, input logic kern, input logic [1:0] st,
                        input logic [PFN_W-1:0] pfn, input logic u, input logic d,
                        input string tag);
    exp_t e;
    e.st = st;
    e.pa = (st == 2'd1) ? {pfn, off} : '0;
    e.u  = u;
    e.d  = d;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    lk_valid = 1; lk_va = {vpn, off}; lk_write = wr; lk_kernel = kern;
    #(CLK_P/4);
    while (!lk_ready) begin
      @(negedge clk);
      #(CLK_P/4);
    end
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                      input logic [3:0] perm, input logic d);
    @(negedge clk);
    fl_valid = 1; fl_vpn = vpn; fl_pfn = pfn; fl_perm = perm; fl_dirty = d;
    #(CLK_P/4);
    while (!fl_ready) begin
      @(negedge clk);
      #(CLK_P/4);
    end
    @(negedge clk);
    fl_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(expq.size() == 0, "R10 drain", 64'(expq.size()), 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  localparam logic [VPN_W-1:0] VE = 35'h1_2345_0001, VF = 35'h0_0000_0F0F, VG = 35'h7_FFFF_FFFF;
  localparam logic [PFN_W-1:0] PE = 32'hDEAD_0001, PF = 32'h0000_0002, PG = 32'hFFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #(CLK_P/4);
    // R1: reset state
    chk(rs_valid == 0, "R1 rs_valid after reset", 64'(rs_valid), 64'h0);
    chk(lk_ready == 1, "R1 lk_ready after reset", 64'(lk_ready), 64'h1);
    chk(fl_ready == 1, "R1 fl_ready after reset", 64'(fl_ready), 64'h1);
    lookup(VE, 13'h5, 0, 0, 2'd0, '0, 0, 0, "R1 empty miss");

    fill(VE, PE, 4'b0001, 0);
    fill(VF, PF, 4'b1111, 0);
    fill(VG, PG, 4'b0100, 1);

    // R2/R3/R4/R5 on entry E (user read only)
    lookup(VE, 13'h123,  0, 0, 2'd1, PE, 0, 0, "R2 user read hit");
    lookup(VE, 13'h1FFF, 0, 0, 2'd1, PE, 1, 0, "R4 used set by hit");
    lookup(VE, 13'h0,    1, 0, 2'd2, PE, 1, 0, "R3 user write fault");
    lookup(VE, 13'h0,    0, 1, 2'd2, PE, 1, 0, "R3 kernel read fault");
    lookup(VE, 13'h7,    0, 0, 2'd1, PE, 1, 0, "R5 fault write no dirty");
    // entry F (all permissions)
    lookup(VF, 13'h0AA, 1, 1, 2'd1, PF, 0, 0, "R2 kernel write hit");
    lookup(VF, 13'h0,   0, 0, 2'd1, PF, 1, 1, "R5 dirty set by write");
    lookup(VF, 13'h1,   1, 0, 2'd1, PF, 1, 1, "R3 user write allowed");
    // entry G (kernel read only, filled modified)
    lookup(VG, 13'h1000, 0, 1, 2'd1, PG, 0, 1, "R5 fill loads dirty");
    lookup(VG, 13'h0,    0, 0, 2'd2, PG, 1, 1, "R3 user read fault");
    lookup(VG, 13'h0,    1, 1, 2'd2, PG, 1, 1, "R4 fault sets used");

    // R8 / R11: single invalidation
    @(negedge clk);
    inv_en = 1; inv_vpn = VF;
    #(CLK_P/4);
    chk(fl_ready == 0, "R11 fl_ready during inv_en", 64'(fl_ready), 64'h0);
    @(negedge clk);
    inv_en = 0;
    lookup(VF, 13'h0, 0, 0, 2'd0, '0, 0, 0, "R8 invalidated miss");
    lookup(VE, 13'h3, 0, 0, 2'd1, PE, 1, 0, "R8 other entry kept");

    // R9 / R11: flush
    @(negedge clk);
    inv_all = 1;
    #(CLK_P/4);
    chk(fl_ready == 0, "R11 fl_ready during inv_all", 64'(fl_ready), 64'h0);
    @(negedge clk);
    inv_all = 0;
    lookup(VE, 13'h0, 0, 0, 2'd0, '0, 0, 0, "R9 flush miss E");
    lookup(VG, 13'h0, 0, 1, 2'd0, '0, 0, 0, "R9 flush miss G");

    // R6: fill the table, open one slot, refill it
    for (int i = 0; i < 16; i++) fill(35'h1000 + 35'(i), 32'h0010_0000 + 32'(i), 4'b0001, 0);
    @(negedge clk);
    inv_en = 1; inv_vpn = 35'h1005;
    @(negedge clk);
    inv_en = 0;
    fill(35'h2000, 32'h0020_0000, 4'b0001, 0);
    for (int i = 0; i < 16; i++) begin
      if (i != 5) lookup(35'h1000 + 35'(i), 13'(i), 0, 0, 2'd1, 32'h0010_0000 + 32'(i), 0, 0, "R6 kept entry");
    end
    lookup(35'h2000, 13'h2, 0, 0, 2'd1, 32'h0020_0000, 0, 0, "R6 new entry");

    // R7: full table, rotating replacement from index 0
    fill(35'h3000, 32'h0030_0000, 4'b0001, 0);
    lookup(35'h1000, 13'h0, 0, 0, 2'd0, '0, 0, 0, "R7 slot0 evicted");
    lookup(35'h1001, 13'h0, 0, 0, 2'd1, 32'h0010_0001, 1, 0, "R7 slot1 kept");
    lookup(35'h3000, 13'h0, 0, 0, 2'd1, 32'h0030_0000, 0, 0, "R7 first replacement");
    fill(35'h3001, 32'h0030_0001, 4'b0001, 0);
    lookup(35'h1001, 13'h0, 0, 0, 2'd0, '0, 0, 0, "R7 slot1 evicted");
    lookup(35'h1002, 13'h0, 0, 0, 2'd1, 32'h0010_0002, 1, 0, "R7 slot2 kept");
    lookup(35'h3001, 13'h0, 0, 0, 2'd1, 32'h0030_0001, 0, 0, "R7 second replacement");
    drain();

    // R10: back-pressure
    @(negedge clk);
    rs_ready = 0;
    fork
      begin
        lookup(35'h2000, 13'h11, 0, 0, 2'd1, 32'h0020_0000, 1, 0, "R10 first in order");
        lookup(35'h3000, 13'h22, 0, 0, 2'd1, 32'h0030_0000, 1, 0, "R10 second in order");
      end
      begin
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        chk(lk_ready == 0, "R10 lk_ready low while stalled", 64'(lk_ready), 64'h0);
        chk(rs_valid == 1, "R10 result held valid", 64'(rs_valid), 64'h1);
        chk(rs_pa == {32'h0020_0000, 13'h11}, "R10 held pa", 64'(rs_pa), 64'({32'h0020_0000, 13'h11}));
        @(negedge clk);
        rs_ready = 1;
      end
    join
    drain();
    finish_run();
  end
endmodule